// File: doc/BRIEF.md
# Zero-Substitution Decoder for Bipolar Line Data

This block sits behind a line receiver that has already sliced the bipolar signal into a positive-pulse stream and a negative-pulse stream and recovered a bit clock. On each clock it takes one bit period of line data. It recognises the substitution patterns that a transmitter inserts to break up long zero runs, and it replaces each recognised pattern with plain zeros. B8ZS is used on 1.544 Mb/s links and HDB3 on 2.048 Mb/s links.

One mode input chooses the substitution scheme. An enable input decides whether recognised patterns are stripped or passed through untouched. All outputs are delayed by an eight-bit window, so a whole B8ZS pattern is held inside the block before any bit of it leaves. A one-period marker flags the start of every stripped pattern. A violation flag reports pulses that break the alternate-mark rule. Violations that belong to a stripped pattern are not reported.

Top module: `zsub_decoder`

## Requirements
- R1: With `hdb3_mode`=0 and `strip_en`=1, the eight-bit pattern 0,0,0,V,B,0,V,B is output as eight zeros. In that pattern the pulse at the fifth bit is opposite in polarity to the pulse at the fourth bit, the seventh bit matches the fifth, and the eighth bit matches the fourth. Every other bit passes unchanged.
- R2: With `hdb3_mode`=1 and `strip_en`=1, both four-bit patterns are output as four zeros. The first is 0,0,0,V, where V has the same polarity as the last pulse before it. The second is B,0,0,V, where V has the same polarity as B. Every other bit passes unchanged.
- R3: With `strip_en`=0, the outputs repeat the line inputs unchanged in either mode, and `cw_mark` stays 0.
- R4: A bit sampled on a rising edge appears on `dec_pos`/`dec_neg` just after the eighth rising edge that follows it.
- R5: `cw_mark` is 1 for exactly one bit period per stripped pattern. That period is the one in which the pattern's first bit appears on the outputs.
- R6: `viol_flag` is 1, aligned with the output bit, for a pulse whose polarity equals that of the previous valid input pulse. The first pulse after reset is never flagged. Violation pulses inside a stripped pattern are not flagged.
- R7: An input period with both `line_pos` and `line_neg` high is treated as a zero. It does not change the polarity history used by R2 and R6.
- R8: While `rst_n` is low, all four outputs are 0. A positive pulse is encoded as `line_pos`=1, `line_neg`=0, and a negative pulse as the reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdb3_mode | input | 1 | 0 selects B8ZS, 1 selects HDB3 |
| strip_en | input | 1 | 1 strips recognised patterns, 0 passes them through |
| line_pos | input | 1 | Positive-pulse bit stream |
| line_neg | input | 1 | Negative-pulse bit stream |
| dec_pos | output | 1 | Decoded positive-pulse stream |
| dec_neg | output | 1 | Decoded negative-pulse stream |
| cw_mark | output | 1 | Marks the first output bit of a stripped pattern |
| viol_flag | output | 1 | Bipolar violation seen on the current output bit |

## Verification
The main stream is a lead-in one followed by every eight-bit data value in ascending order. Encoded with each scheme, this stream holds zero runs of every length up to fifteen bits. Long runs give back-to-back HDB3 patterns of both kinds, chosen by pulse-count parity, and B8ZS patterns with trailing zeros. Running each encoding with stripping on and then off separates three kinds of fault: a wrong pattern match, which corrupts data or misses a marker; a wrong mask width, which zeroes too few or too many bits; and leaked violation flags. A short directed stream with a both-high period checks that invalid input does not disturb the polarity history.

// File: rtl/zsub_decoder.sv
module zsub_decoder (
  input  logic clk,
  input  logic rst_n,
  input  logic hdb3_mode,
  input  logic strip_en,
  input  logic line_pos,
  input  logic line_neg,
  output logic dec_pos,
  output logic dec_neg,
  output logic cw_mark,
  output logic viol_flag
);

  logic [7:0] rp, rn, kill, mark, vmark;
  logic [7:0] wp, wn, wz;
  logic       pi, ni, lastneg, seen;
  logic       b8_hit, hd_hit, hit, in_viol;

  assign pi = line_pos & ~line_neg;
  assign ni = line_neg & ~line_pos;
  assign wp = {rp[6:0], pi};
  assign wn = {rn[6:0], ni};
  assign wz = ~(wp | wn);

  assign b8_hit = wz[7] & wz[6] & wz[5] & wz[2]
                & ~wz[4] & ~wz[3] & ~wz[1] & ~wz[0]
                & (wn[3] != wn[4]) & (wn[1] == wn[3]) & (wn[0] == wn[4]);

  assign hd_hit = wz[2] & wz[1] & ~wz[0]
                & ((~wz[3] & (wn[3] == wn[0])) | (wz[3] & seen & (wn[0] == lastneg)));

  assign hit     = strip_en & (hdb3_mode ? hd_hit : b8_hit);
  assign in_viol = (pi | ni) & seen & (ni == lastneg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp <= '0; rn <= '0; kill <= '0; mark <= '0; vmark <= '0;
      lastneg <= 1'b0; seen <= 1'b0;
      dec_pos <= 1'b0; dec_neg <= 1'b0; cw_mark <= 1'b0; viol_flag <= 1'b0;
    end else begin
      rp    <= wp;
      rn    <= wn;
      kill  <= {kill[6:0], 1'b0} | (hit ? (hdb3_mode ? 8'h0F : 8'hFF) : 8'h00);
      mark  <= {mark[6:0], 1'b0} | (hit ? (hdb3_mode ? 8'h08 : 8'h80) : 8'h00);
      vmark <= {vmark[6:0], in_viol};
      if (pi | ni) begin
        lastneg <= ni;
        seen    <= 1'b1;
      end
      dec_pos   <= rp[7] & ~kill[7];
      dec_neg   <= rn[7] & ~kill[7];
      cw_mark   <= mark[7];
      viol_flag <= vmark[7] & ~kill[7];
    end
  end

  // R8
  polarity_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec_pos, dec_neg}));

  // R6
  viol_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_flag |-> (dec_pos | dec_neg));

  // R5
  mark_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_mark |-> (!dec_pos && !dec_neg));

  // R5
  mark_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_mark |=> !cw_mark);

endmodule

// File: tb/test_zsub_decoder.sv
module test_zsub_decoder;
  localparam int ND = 2049;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, hdb3_mode, strip_en, line_pos, line_neg;
  logic dec_pos, dec_neg, cw_mark, viol_flag;

  int errs = 0;
  int checks = 0;

  logic dbit [0:ND-1];
  logic lp [0:ND-1];
  logic ln [0:ND-1];
  logic xp [0:ND-1];
  logic xn [0:ND-1];
  logic xs [0:ND-1];
  logic xv [0:ND-1];

  zsub_decoder i_zsub_decoder (
    .clk(clk), .rst_n(rst_n), .hdb3_mode(hdb3_mode), .strip_en(strip_en),
    .line_pos(line_pos), .line_neg(line_neg),
    .dec_pos(dec_pos), .dec_neg(dec_neg), .cw_mark(cw_mark), .viol_flag(viol_flag)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input int k, input logic pulse, input logic neg, input logic code,
                     input logic first, input logic isv, input logic en);
    lp[k] = pulse & ~neg;
    ln[k] = pulse & neg;
    xp[k] = (en & code) ? 1'b0 : lp[k];
    xn[k] = (en & code) ? 1'b0 : ln[k];
    xs[k] = en & code & first;
    xv[k] = isv & ~(en & code);
  endtask

  task automatic build(input logic hd, input logic en);
    int i = 0;
    int cnt = 0;
    logic lneg = 1'b1;
    while (i < ND) begin
      bit run8 = (i + 7 < ND);
      bit run4 = (i + 3 < ND);
      for (int k = 0; k < 8; k++) begin
        if (i + k >= ND || dbit[i + k]) begin
          if (k < 8) run8 = 0;
          if (k < 4) run4 = 0;
        end
      end
      if (!hd && run8) begin
        put(i, 0, 0, 1, 1, 0, en);     put(i + 1, 0, 0, 1, 0, 0, en);
        put(i + 2, 0, 0, 1, 0, 0, en); put(i + 3, 1, lneg, 1, 0, 1, en);
        put(i + 4, 1, ~lneg, 1, 0, 0, en); put(i + 5, 0, 0, 1, 0, 0, en);
        put(i + 6, 1, ~lneg, 1, 0, 1, en); put(i + 7, 1, lneg, 1, 0, 0, en);
        i += 8;
      end else if (hd && run4) begin
        if (cnt % 2 == 1) begin
          put(i, 0, 0, 1, 1, 0, en); put(i + 1, 0, 0, 1, 0, 0, en);
          put(i + 2, 0, 0, 1, 0, 0, en); put(i + 3, 1, lneg, 1, 0, 1, en);
        end else begin
          put(i, 1, ~lneg, 1, 1, 0, en); put(i + 1, 0, 0, 1, 0, 0, en);
          put(i + 2, 0, 0, 1, 0, 0, en); put(i + 3, 1, ~lneg, 1, 0, 1, en);
          lneg = ~lneg;
        end
        cnt = 0;
        i += 4;
      end else if (dbit[i]) begin
        put(i, 1, ~lneg, 0, 0, 0, en);
        lneg = ~lneg;
        cnt++;
        i++;
      end else begin
        put(i, 0, 0, 0, 0, 0, en);
        i++;
      end
    end
  endtask

  task automatic run(input int n, input logic hd, input logic en, input string dtag);
    @(negedge clk);
    rst_n = 1'b0; hdb3_mode = hd; strip_en = en; line_pos = 0; line_neg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int j = 0; j < n + 9; j++) begin
      if (j >= 9) begin
        int k = j - 9;
        check(dec_pos === xp[k], {dtag, " R4 pos"}, int'(dec_pos), int'(xp[k]));
        check(dec_neg === xn[k], {dtag, " R4 neg"}, int'(dec_neg), int'(xn[k]));
        check(cw_mark === xs[k], "R5 mark", int'(cw_mark), int'(xs[k]));
        check(viol_flag === xv[k], "R6 viol", int'(viol_flag), int'(xv[k]));
      end
      line_pos = (j < n) ? lp[j] : 1'b0;
      line_neg = (j < n) ? ln[j] : 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hdb3_mode = 0; strip_en = 1; line_pos = 1; line_neg = 0;
    repeat (4) @(negedge clk);
    // R8: outputs held low under reset despite activity
    check({dec_pos, dec_neg, cw_mark, viol_flag} === 4'b0, "R8 reset",
          int'({dec_pos, dec_neg, cw_mark, viol_flag}), 0);

    dbit[0] = 1'b1;
    for (int b = 0; b < 256; b++)
      for (int t = 0; t < 8; t++)
        dbit[1 + b * 8 + t] = b[7 - t];

    build(0, 1); run(ND, 0, 1, "R1");
    build(1, 1); run(ND, 1, 1, "R2");
    build(0, 0); run(ND, 0, 0, "R3");
    build(1, 0); run(ND, 1, 0, "R3");

    // R7: both-high period counts as zero and leaves polarity history alone
    lp[0] = 1; ln[0] = 0; xp[0] = 1; xn[0] = 0; xs[0] = 0; xv[0] = 0;
    lp[1] = 1; ln[1] = 1; xp[1] = 0; xn[1] = 0; xs[1] = 0; xv[1] = 0;
    lp[2] = 1; ln[2] = 0; xp[2] = 1; xn[2] = 0; xs[2] = 0; xv[2] = 1;
    lp[3] = 0; ln[3] = 1; xp[3] = 0; xn[3] = 1; xs[3] = 0; xv[3] = 0;
    run(4, 0, 1, "R7");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule